// File: doc/BRIEF.md
# Fetch-Execute Bus Cycle Sequencer

This block produces the bus activity of a simplified processor, one instruction at a time. A start request from an idle state opens a single-clock fetch cycle. The instruction pointer goes out on the address bus, and the instruction word coming back on the data input is captured. In the same clock edge that ends the fetch, the block samples a request from a decoder stub. The request names one of none, memory read, memory write, I/O read or I/O write, together with an address and write data. Every request other than none produces one further single-clock execute cycle.

Each bus cycle is marked by a three-signal code: memory-versus-I/O select, write-versus-read direction, and data-versus-control phase. An active strobe qualifies the code. The processor drives its data output, and raises the output-enable, only for writes. For a read it leaves the bus alone and captures the returned word at the end of the cycle. The instruction pointer advances by a fixed instruction length after every fetch.

Top module: `bus_cycle_seq`

## Requirements
- R1: During and straight after reset, busy, the cycle strobe and the output-enable are low, the instruction pointer equals RESET_IP (0 by default), and the captured instruction and read data are both 0.
- R2: When start is high at a clock edge while the block is idle, the next clock is a fetch cycle. In that cycle the strobe is 1, the memory select is 1, the write select is 0, the data/control select is 0, the address equals the instruction pointer, and the output-enable is 0.
- R3: At the end of a fetch cycle, the instruction output takes the value on the data input, and the instruction pointer grows by 4 modulo 2^32. The pointer changes at no other time.
- R4: Request codes are 1 = memory read, 2 = memory write, 3 = I/O read and 4 = I/O write. Each produces exactly one execute cycle right after the fetch, with data/control select 1. The memory select is 1 for codes 1 and 2 and 0 for codes 3 and 4. The write select is 1 for codes 2 and 4 and 0 for codes 1 and 3.
- R5: Request code 0 (none) and the unused codes 5 to 7 produce no execute cycle. The clock after the fetch is idle, with the strobe and busy both low.
- R6: The output-enable is high only during a write execute cycle, and in that cycle the data output carries the write data sampled at the end of the fetch.
- R7: At the end of a read execute cycle, memory or I/O, the read-data output takes the data input. Fetches, writes and idle clocks leave it unchanged.
- R8: Busy is high from the fetch cycle through the end of any execute cycle and low otherwise. A start request made while busy is ignored.
- R9: The execute cycle uses the address, kind and write data sampled at the end of the fetch. Changes to those inputs during the execute cycle have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new instruction when idle |
| req_kind_i | input | 3 | Execute request code from the decoder stub |
| req_addr_i | input | 32 | Execute-phase address |
| req_wdata_i | input | 32 | Execute-phase write data |
| bus_din_i | input | 32 | Data returned by memory or I/O |
| bus_cyc_o | output | 1 | A bus cycle is active this clock |
| sel_mem_o | output | 1 | 1 = memory, 0 = I/O |
| sel_write_o | output | 1 | 1 = processor writes, 0 = processor reads |
| sel_data_o | output | 1 | 1 = execute-phase data, 0 = instruction fetch |
| bus_addr_o | output | 32 | Address bus |
| bus_dout_o | output | 32 | Processor data output |
| bus_oe_o | output | 1 | Data output enable |
| busy_o | output | 1 | Instruction in progress |
| instr_o | output | 32 | Last fetched instruction word |
| rdata_o | output | 32 | Last execute-phase read data |
| ip_o | output | 32 | Instruction pointer |

## Verification
The sequence runs with every request kind against a behavioural memory and I/O model. Memory and I/O reads return different functions of the address, so a swapped select shows up as a wrong captured word. A memory write followed by a read of the same word shows that the enabled data reached the model. Kind 0 and the unused kind 6 show that no execute cycle is issued. The decoder inputs are scrambled during the execute cycle to separate latched values from live ones. Start is also held high through a whole instruction to show that it is ignored while busy.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

  localparam logic [2:0] K_NONE   = 3'd0;
  localparam logic [2:0] K_MEM_RD = 3'd1;
  localparam logic [2:0] K_MEM_WR = 3'd2;
  localparam logic [2:0] K_IO_RD  = 3'd3;
  localparam logic [2:0] K_IO_WR  = 3'd4;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_EXEC  = 2'd2
  } phase_e;

  typedef struct packed {
    logic cyc;
    logic mem;
    logic wr;
    logic dat;
  } bus_code_t;

  function automatic logic kind_has_exec(input logic [2:0] k);
    return (k == K_MEM_RD) || (k == K_MEM_WR) || (k == K_IO_RD) || (k == K_IO_WR);
  endfunction

  function automatic logic kind_is_write(input logic [2:0] k);
    return (k == K_MEM_WR) || (k == K_IO_WR);
  endfunction

  function automatic logic kind_is_mem(input logic [2:0] k);
    return (k == K_MEM_RD) || (k == K_MEM_WR);
  endfunction

  function automatic bus_code_t code_for(input phase_e ph, input logic [2:0] k);
    bus_code_t c;
    c = '0;
    case (ph)
      PH_FETCH: begin
        c.cyc = 1'b1;
        c.mem = 1'b1;
        c.wr  = 1'b0;
        c.dat = 1'b0;
      end
      PH_EXEC: begin
        c.cyc = 1'b1;
        c.mem = kind_is_mem(k);
        c.wr  = kind_is_write(k);
        c.dat = 1'b1;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/bseq_phase_ctl.sv
module bseq_phase_ctl
  import busseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [2:0] kind_i,
  output phase_e     phase_o,
  output logic       fetch_done_o,
  output logic       exec_done_o
);

  phase_e phase_q, phase_nx;

  always_comb begin
    phase_nx = phase_q;
    case (phase_q)
      PH_IDLE:  if (start_i) phase_nx = PH_FETCH;
      PH_FETCH: phase_nx = kind_has_exec(kind_i) ? PH_EXEC : PH_IDLE;
      PH_EXEC:  phase_nx = PH_IDLE;
      default:  phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_nx;
  end

  assign phase_o      = phase_q;
  assign fetch_done_o = (phase_q == PH_FETCH);
  assign exec_done_o  = (phase_q == PH_EXEC);

  AST_START_OPENS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && start_i) |=> (phase_q == PH_FETCH)); // R2
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_EXEC) |=> (phase_q == PH_IDLE)); // R8
  AST_NONE_SKIPS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FETCH && !kind_has_exec(kind_i)) |=> (phase_q == PH_IDLE)); // R5
  AST_EXEC_FOLLOWS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_EXEC) |-> ($past(phase_q) == PH_FETCH)); // R4

endmodule

// File: rtl/bseq_ptr_reg.sv
module bseq_ptr_reg #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int STEP     = 4,
  parameter logic [AW-1:0] RESET_IP = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_done_i,
  input  logic [DW-1:0] din_i,
  output logic [AW-1:0] ip_o,
  output logic [DW-1:0] instr_o
);

  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  function automatic logic [AW-1:0] ip_advance(input logic [AW-1:0] ip);
    return ip + STEP_V;
  endfunction

  logic [AW-1:0] ip_q;
  logic [DW-1:0] instr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_q    <= RESET_IP;
      instr_q <= '0;
    end else if (fetch_done_i) begin
      ip_q    <= ip_advance(ip_q);
      instr_q <= din_i;
    end
  end

  assign ip_o    = ip_q;
  assign instr_o = instr_q;

  AST_IP_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done_i |=> (ip_q == $past(ip_q) + STEP_V)); // R3
  AST_IP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_done_i |=> $stable(ip_q)); // R3
  AST_INSTR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done_i |=> (instr_q == $past(din_i))); // R3

endmodule

// File: rtl/bseq_bus_drv.sv
module bseq_bus_drv
  import busseq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase_i,
  input  logic          fetch_done_i,
  input  logic          exec_done_i,
  input  logic [2:0]    kind_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] ip_i,
  input  logic [DW-1:0] din_i,
  output bus_code_t     code_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dout_o,
  output logic          oe_o,
  output logic [DW-1:0] rdata_o
);

  logic [2:0]    kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          exec_read_done;
  bus_code_t     code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= K_NONE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (fetch_done_i) begin
      kind_q  <= kind_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  assign exec_read_done = exec_done_i && !kind_is_write(kind_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rdata_q <= '0;
    else if (exec_read_done) rdata_q <= din_i;
  end

  assign code = code_for(phase_i, kind_q);

  always_comb begin
    case (phase_i)
      PH_FETCH: addr_o = ip_i;
      PH_EXEC:  addr_o = addr_q;
      default:  addr_o = '0;
    endcase
  end

  assign oe_o    = code.cyc && code.wr;
  assign dout_o  = oe_o ? wdata_q : '0;
  assign code_o  = code;
  assign rdata_o = rdata_q;

  AST_OE_ONLY_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    oe_o |-> (phase_i == PH_EXEC)); // R6
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_read_done |=> $stable(rdata_q)); // R7
  AST_RDATA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_read_done |=> (rdata_q == $past(din_i))); // R7
  AST_EXEC_ADDR_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_EXEC) |-> (addr_o == $past(addr_i))); // R9

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import busseq_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int ILEN     = 4,
  parameter logic [AW-1:0] RESET_IP = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [2:0]    req_kind_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [DW-1:0] bus_din_i,
  output logic          bus_cyc_o,
  output logic          sel_mem_o,
  output logic          sel_write_o,
  output logic          sel_data_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_dout_o,
  output logic          bus_oe_o,
  output logic          busy_o,
  output logic [DW-1:0] instr_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] ip_o
);

  phase_e        phase;
  logic          fetch_done;
  logic          exec_done;
  logic [AW-1:0] ip;
  bus_code_t     code;

  bseq_phase_ctl u_phase (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .kind_i       (req_kind_i),
    .phase_o      (phase),
    .fetch_done_o (fetch_done),
    .exec_done_o  (exec_done)
  );

  bseq_ptr_reg #(
    .AW       (AW),
    .DW       (DW),
    .STEP     (ILEN),
    .RESET_IP (RESET_IP)
  ) u_ptr (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_done_i (fetch_done),
    .din_i        (bus_din_i),
    .ip_o         (ip),
    .instr_o      (instr_o)
  );

  bseq_bus_drv #(
    .AW (AW),
    .DW (DW)
  ) u_drv (
    .clk          (clk),
    .rst_n        (rst_n),
    .phase_i      (phase),
    .fetch_done_i (fetch_done),
    .exec_done_i  (exec_done),
    .kind_i       (req_kind_i),
    .addr_i       (req_addr_i),
    .wdata_i      (req_wdata_i),
    .ip_i         (ip),
    .din_i        (bus_din_i),
    .code_o       (code),
    .addr_o       (bus_addr_o),
    .dout_o       (bus_dout_o),
    .oe_o         (bus_oe_o),
    .rdata_o      (rdata_o)
  );

  assign bus_cyc_o   = code.cyc;
  assign sel_mem_o   = code.mem;
  assign sel_write_o = code.wr;
  assign sel_data_o  = code.dat;
  assign busy_o      = (phase != PH_IDLE);
  assign ip_o        = ip;

  AST_FETCH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc_o && !sel_data_o) |-> (sel_mem_o && !sel_write_o && !bus_oe_o && bus_addr_o == ip_o)); // R2
  AST_BUSY_STARTS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (bus_cyc_o && !sel_data_o)); // R8
  AST_DATA_PHASE_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cyc_o && sel_data_o) |-> ($past(bus_cyc_o) && !$past(sel_data_o))); // R4
  AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe_o |-> (bus_cyc_o && sel_write_o && sel_data_o)); // R6

endmodule

// File: tb/bus_cycle_seq_bench.sv
module bus_cycle_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  req_kind_i = 3'd0;
  logic [31:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic [31:0] bus_din_i;
  logic        bus_cyc_o, sel_mem_o, sel_write_o, sel_data_o, bus_oe_o, busy_o;
  logic [31:0] bus_addr_o, bus_dout_o, instr_o, rdata_o, ip_o;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [31:0] mem [16];
  logic [31:0] io_last = '0;
  logic [31:0] exp_ip = '0;
  logic [31:0] exp_rdata = '0;

  always #10 clk = ~clk;

  bus_cycle_seq u_bus_cycle_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_kind_i(req_kind_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .bus_din_i(bus_din_i),
    .bus_cyc_o(bus_cyc_o), .sel_mem_o(sel_mem_o), .sel_write_o(sel_write_o),
    .sel_data_o(sel_data_o), .bus_addr_o(bus_addr_o), .bus_dout_o(bus_dout_o),
    .bus_oe_o(bus_oe_o), .busy_o(busy_o), .instr_o(instr_o), .rdata_o(rdata_o),
    .ip_o(ip_o)
  );

  function automatic logic [31:0] io_value(input logic [31:0] a);
    return a ^ 32'hC0DE_0000;
  endfunction

  always_comb begin
    bus_din_i = 32'h0;
    if (bus_cyc_o && !sel_write_o)
      bus_din_i = sel_mem_o ? mem[bus_addr_o[5:2]] : io_value(bus_addr_o);
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h1000_0000 + 32'(i * 17);
  end

  always @(posedge clk) begin
    if (bus_cyc_o && sel_write_o && bus_oe_o) begin
      if (sel_mem_o) mem[bus_addr_o[5:2]] <= bus_dout_o;
      else           io_last <= bus_dout_o;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 busy", 32'(busy_o), 0);
    check("R1 cyc", 32'(bus_cyc_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 oe", 32'(bus_oe_o), 0);
    check("R1 ip", ip_o, 0);
    check("R1 instr", instr_o, 0);
    check("R1 rdata", rdata_o, 0);
  endtask

  task automatic run_instr(input logic [2:0] k, input logic [31:0] a,
                           input logic [31:0] w, input bit hold_start);
    logic [31:0] exp_instr;
    logic [31:0] rd_val;
    bit has_exec, is_wr, is_mem;
    has_exec = (k >= 3'd1 && k <= 3'd4);
    is_wr    = (k == 3'd2 || k == 3'd4);
    is_mem   = (k == 3'd1 || k == 3'd2);
    exp_instr = mem[exp_ip[5:2]];
    start_i = 1'b1; req_kind_i = k; req_addr_i = a; req_wdata_i = w;
    @(negedge clk);
    // fetch cycle
    check("R2 cyc", 32'(bus_cyc_o), 1);
    check("R2 code", {29'd0, sel_mem_o, sel_write_o, sel_data_o}, 32'b100);
    check("R2 addr", bus_addr_o, exp_ip);
    check("R2 oe", 32'(bus_oe_o), 0);
    check("R8 busy in fetch", 32'(busy_o), 1);
    if (!hold_start) start_i = 1'b0;
    @(negedge clk);
    check("R3 instr", instr_o, exp_instr);
    check("R3 ip step", ip_o, exp_ip + 32'd4);
    exp_ip = exp_ip + 32'd4;
    if (has_exec) begin
      rd_val = is_mem ? mem[a[5:2]] : io_value(a);
      check("R4 cyc", 32'(bus_cyc_o), 1);
      check("R4 code", {29'd0, sel_mem_o, sel_write_o, sel_data_o},
            {29'd0, is_mem, is_wr, 1'b1});
      check("R9 addr", bus_addr_o, a);
      check("R6 oe", 32'(bus_oe_o), 32'(is_wr));
      if (is_wr) check("R6 dout", bus_dout_o, w);
      check("R8 busy in exec", 32'(busy_o), 1);
      req_kind_i = 3'd0; req_addr_i = ~a; req_wdata_i = ~w;
      #1;
      check("R9 addr after input change", bus_addr_o, a);
      if (is_wr) check("R9 dout after input change", bus_dout_o, w);
      @(negedge clk);
      if (!is_wr) exp_rdata = rd_val;
      check("R7 rdata", rdata_o, exp_rdata);
      check("R8 idle after exec", 32'(busy_o), 0);
      if (is_wr && is_mem) check("R6 mem written", mem[a[5:2]], w);
      if (is_wr && !is_mem) check("R6 io written", io_last, w);
      check("R3 ip held", ip_o, exp_ip);
    end else begin
      check("R5 no exec cyc", 32'(bus_cyc_o), 0);
      check("R5 idle", 32'(busy_o), 0);
      check("R7 rdata unchanged", rdata_o, exp_rdata);
    end
    start_i = 1'b0; req_kind_i = 3'd0;
    @(negedge clk);
    check("R8 stays idle", 32'(busy_o), 0);
  endtask

  initial begin
    test_reset();
    run_instr(3'd1, 32'h0000_0014, 32'h0, 1'b0);          // R4 mem read
    run_instr(3'd2, 32'h0000_0020, 32'hDEAD_BEEF, 1'b0);  // R6 mem write
    run_instr(3'd1, 32'h0000_0020, 32'h0, 1'b0);          // R7 read back
    run_instr(3'd4, 32'h0000_0300, 32'h1234_5678, 1'b0);  // R4 io write
    run_instr(3'd3, 32'h0000_0060, 32'h0, 1'b0);          // R4 io read
    run_instr(3'd0, 32'h0000_0008, 32'h0, 1'b0);          // R5 none
    run_instr(3'd6, 32'h0000_0008, 32'h5555_AAAA, 1'b0);  // R5 unused code
    run_instr(3'd2, 32'h0000_0004, 32'hA5A5_0F0F, 1'b1);  // R8 start held
    run_instr(3'd1, 32'h0000_0004, 32'h0, 1'b1);          // R8 start held, read
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule